// File: doc/BRIEF.md
# OScan1 Target Bit Adapter

This block sits on the target side of a two-wire debug link. The link runs in the three-slot scan format. The adapter turns the shared data line (TMSC) and its clock (TCKC) into the four TAP signals of an ordinary internal boundary-scan controller. Every TAP bit travels as a packet of three TCKC clocks. The first slot carries TDI in inverted form, the second carries TMS, and in the third the target returns TDO. The adapter undoes the inversion and presents TDI and TMS to the TAP. It makes one internal TCK pulse per packet and drives the captured TDO back onto the line during the last slot. It also tells a weak line keeper when to hold the line and at which level.

The slot position is held in a three-state machine clocked on the rising edge of TCKC. The states are `SLOT_NTDI`, `SLOT_TMS` and `SLOT_TDO`. Its normal transitions are `SLOT_NTDI -> SLOT_TMS` (inverted TDI captured), `SLOT_TMS -> SLOT_TDO` (TMS captured, TCK raised, TDO latched) and `SLOT_TDO -> SLOT_NTDI` (packet complete). A forced return `any -> SLOT_NTDI` happens on every rising edge where the format is inactive or an escape has been flagged. A falling-edge stage decides when the line is driven and records the keeper level. Escape detection and the TAP state machine live outside this block.

Top module: `oscan1_bit_adapter`

## Requirements
- R1: While `rst_n` is low and after it, before any packet, `tap_tck`, `tmsc_oe`, `tap_tdi`, `tap_tms` and `keep_lvl` are 0. `keep_en` is 0 while `oscan_en` is 0.
- R2: On the rising TCKC edge that ends the first slot of a packet, `tap_tdi` takes the inverse of the line level.
- R3: On the rising TCKC edge that ends the second slot, `tap_tms` takes the line level.
- R4: `tap_tck` goes high right after the rising edge that ends the second slot and low at the following falling edge. That is exactly one pulse, half a TCKC period wide, per packet.
- R5: The `tap_tdo` value sampled on the rising edge that raised `tap_tck` is driven on `tmsc_o` with `tmsc_oe` high. This lasts from the next falling edge until the rising edge that ends the third slot. Later changes on `tap_tdo` do not alter it.
- R6: `tmsc_oe` is low during the first two slots, during the first half of the third slot, and at all times while `oscan_en` is low.
- R7: When `escape` is high at a rising edge, the packet is abandoned. No capture into `tap_tdi` or `tap_tms`, no `tap_tck` pulse and no line drive result from it, and the next slot is the inverted-TDI slot.
- R8: While `oscan_en` is low, `tap_tck` stays low and `tap_tdi`/`tap_tms` hold their values. Raising `oscan_en` makes the next slot the inverted-TDI slot, even if a packet had been partly sent.
- R9: `keep_en` is high exactly when `oscan_en` is high and `tmsc_oe` is low. `keep_lvl` is the level present at the last falling edge: the driven TDO bit if driving started there, otherwise the line level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tckc | input | 1 | Link clock from the probe |
| rst_n | input | 1 | Asynchronous active-low reset |
| oscan_en | input | 1 | Three-slot format is active |
| escape | input | 1 | Escape seen by the external detector, synchronous to TCKC |
| tmsc_i | input | 1 | Resolved level of the data line |
| tmsc_o | output | 1 | Level to drive on the data line |
| tmsc_oe | output | 1 | Drive enable for the data line |
| keep_en | output | 1 | Keeper may hold the line |
| keep_lvl | output | 1 | Level the keeper holds |
| tap_tck | output | 1 | Internal TAP clock, one pulse per packet |
| tap_tdi | output | 1 | Rebuilt TDI |
| tap_tms | output | 1 | Rebuilt TMS |
| tap_tdo | input | 1 | TDO from the internal TAP |

## Verification
The hardest states to reach from the ports are the abandoned packets. An escape or a dropped enable can land at the end of the inverted-TDI slot or at the end of the TMS slot. Each of these must leave TDI and TMS untouched, suppress the TCK pulse and keep the line released. The bench reaches them by sending a slot, or two slots, with line values opposite to the held TAP inputs. It then raises `escape` or lowers `oscan_en` over the next edge and follows with a full packet, whose fields show that the slot counter restarted at the first slot. All eight combinations of inverted TDI, TMS and TDO are also swept through complete packets. In each packet the bench changes `tap_tdo` after it has been latched, to show that the returned bit is the held one.

// File: rtl/oscan1_pkg.sv
package oscan1_pkg;

    // Position inside one three-clock packet
    typedef enum logic [1:0] {
        SLOT_NTDI = 2'd0,
        SLOT_TMS  = 2'd1,
        SLOT_TDO  = 2'd2
    } slot_e;

endpackage

// File: rtl/oscan1_slot_fsm.sv
// Rising-edge part: slot sequencing and capture of the probe slots.
module oscan1_slot_fsm
    import oscan1_pkg::*;
#(
    parameter bit IDLE_LEVEL = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  esc,
    input  logic  line,
    input  logic  tdo_in,
    output slot_e slot,
    output logic  tdi,
    output logic  tms,
    output logic  tdo_hold
);

    slot_e slot_nxt;
    logic  advance;

    assign advance = en && !esc;

    always_comb begin
        slot_nxt = SLOT_NTDI;
        if (advance) begin
            unique case (slot)
                SLOT_NTDI: slot_nxt = SLOT_TMS;
                SLOT_TMS:  slot_nxt = SLOT_TDO;
                SLOT_TDO:  slot_nxt = SLOT_NTDI;
                default:   slot_nxt = SLOT_NTDI;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= SLOT_NTDI;
        end else begin
            slot <= slot_nxt;
        end
    end

    // Captured outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdi      <= IDLE_LEVEL;
            tms      <= IDLE_LEVEL;
            tdo_hold <= IDLE_LEVEL;
        end else if (advance) begin
            unique case (slot)
                SLOT_NTDI: tdi <= ~line;
                SLOT_TMS: begin
                    tms      <= line;
                    tdo_hold <= tdo_in;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/oscan1_line_drv.sv
// Falling-edge part: TCK shaping, line drive window and keeper level.
module oscan1_line_drv
    import oscan1_pkg::*;
#(
    parameter bit IDLE_LEVEL = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  slot_e slot,
    input  logic  line,
    input  logic  tdo_hold,
    output logic  tck,
    output logic  oe,
    output logic  dout,
    output logic  keep_en,
    output logic  keep_lvl
);

    logic in_tdo;
    logic drive_half;

    assign in_tdo = en && (slot == SLOT_TDO);

    // Second half of the return slot starts at this falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_half <= 1'b0;
            keep_lvl   <= IDLE_LEVEL;
        end else begin
            drive_half <= in_tdo;
            keep_lvl   <= in_tdo ? tdo_hold : line;
        end
    end

    always_comb begin
        tck     = in_tdo && !drive_half;
        oe      = in_tdo && drive_half;
        dout    = tdo_hold;
        keep_en = en && !oe;
    end

endmodule

// File: rtl/oscan1_bit_adapter.sv
module oscan1_bit_adapter
    import oscan1_pkg::*;
#(
    parameter bit IDLE_LEVEL = 1'b0
) (
    input  logic tckc,
    input  logic rst_n,
    input  logic oscan_en,
    input  logic escape,
    input  logic tmsc_i,
    output logic tmsc_o,
    output logic tmsc_oe,
    output logic keep_en,
    output logic keep_lvl,
    output logic tap_tck,
    output logic tap_tdi,
    output logic tap_tms,
    input  logic tap_tdo
);

    slot_e slot;
    logic  tdo_hold;

    oscan1_slot_fsm #(.IDLE_LEVEL(IDLE_LEVEL)) u_fsm (
        .clk      (tckc),
        .rst_n    (rst_n),
        .en       (oscan_en),
        .esc      (escape),
        .line     (tmsc_i),
        .tdo_in   (tap_tdo),
        .slot     (slot),
        .tdi      (tap_tdi),
        .tms      (tap_tms),
        .tdo_hold (tdo_hold)
    );

    oscan1_line_drv #(.IDLE_LEVEL(IDLE_LEVEL)) u_drv (
        .clk      (tckc),
        .rst_n    (rst_n),
        .en       (oscan_en),
        .slot     (slot),
        .line     (tmsc_i),
        .tdo_hold (tdo_hold),
        .tck      (tap_tck),
        .oe       (tmsc_oe),
        .dout     (tmsc_o),
        .keep_en  (keep_en),
        .keep_lvl (keep_lvl)
    );

endmodule

// File: rtl/oscan1_bit_adapter_chk.sv
module oscan1_bit_adapter_chk (
    input logic tckc,
    input logic rst_n,
    input logic oscan_en,
    input logic escape,
    input logic tmsc_o,
    input logic tmsc_oe,
    input logic keep_en,
    input logic tap_tck,
    input logic tap_tdi,
    input logic tap_tms,
    input logic tap_tdo
);

    // R4
    tck_one_halfcycle_chk: assert property (@(negedge tckc) disable iff (!rst_n)
        tap_tck |=> !tap_tck);

    // R5
    tdo_return_chk: assert property (@(posedge tckc) disable iff (!rst_n)
        tmsc_oe |-> (tmsc_o == $past(tap_tdo)));

    // R7
    esc_no_capture_chk: assert property (@(posedge tckc) disable iff (!rst_n)
        escape |=> ($stable(tap_tdi) && $stable(tap_tms)));

    // R6
    idle_quiet_chk: assert property (@(negedge tckc) disable iff (!rst_n)
        !oscan_en |-> (!tap_tck && !tmsc_oe));

    // R9
    keeper_excl_chk: assert property (@(posedge tckc) disable iff (!rst_n)
        tmsc_oe |-> !keep_en);

endmodule

bind oscan1_bit_adapter oscan1_bit_adapter_chk u_chk (
    .tckc     (tckc),
    .rst_n    (rst_n),
    .oscan_en (oscan_en),
    .escape   (escape),
    .tmsc_o   (tmsc_o),
    .tmsc_oe  (tmsc_oe),
    .keep_en  (keep_en),
    .tap_tck  (tap_tck),
    .tap_tdi  (tap_tdi),
    .tap_tms  (tap_tms),
    .tap_tdo  (tap_tdo)
);

// File: tb/oscan1_bit_adapter_bench.sv
module oscan1_bit_adapter_bench;

    localparam int CLK_PERIOD = 10;

    logic tckc = 1'b0;
    logic rst_n = 1'b0;
    logic oscan_en = 1'b0;
    logic escape = 1'b0;
    logic probe = 1'b0;
    logic tap_tdo = 1'b0;
    logic tmsc_i;
    logic tmsc_o, tmsc_oe, keep_en, keep_lvl, tap_tck, tap_tdi, tap_tms;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) tckc = ~tckc;

    assign tmsc_i = tmsc_oe ? tmsc_o : probe;

    oscan1_bit_adapter u_oscan1_bit_adapter (
        .tckc     (tckc),
        .rst_n    (rst_n),
        .oscan_en (oscan_en),
        .escape   (escape),
        .tmsc_i   (tmsc_i),
        .tmsc_o   (tmsc_o),
        .tmsc_oe  (tmsc_oe),
        .keep_en  (keep_en),
        .keep_lvl (keep_lvl),
        .tap_tck  (tap_tck),
        .tap_tdi  (tap_tdi),
        .tap_tms  (tap_tms),
        .tap_tdo  (tap_tdo)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Full packet; called just after a rising edge with the slot at nTDI
    task automatic send_pkt(input logic ntdi, input logic tms, input logic tdo);
        @(negedge tckc); #1;
        chk("R6 oe in slot 1", tmsc_oe, 1'b0);
        probe = ntdi;
        @(posedge tckc); #1;
        chk("R2 tdi", tap_tdi, ~ntdi);
        chk("R4 tck low slot 1", tap_tck, 1'b0);
        @(negedge tckc); #1;
        probe   = tms;
        tap_tdo = tdo;
        @(posedge tckc); #1;
        chk("R3 tms", tap_tms, tms);
        chk("R4 tck high", tap_tck, 1'b1);
        chk("R6 oe before drive", tmsc_oe, 1'b0);
        @(negedge tckc); #1;
        chk("R4 tck low", tap_tck, 1'b0);
        chk("R5 oe", tmsc_oe, 1'b1);
        chk("R5 tdo out", tmsc_o, tdo);
        tap_tdo = ~tdo;
        @(posedge tckc); #1;
        chk("R6 oe released", tmsc_oe, 1'b0);
        chk("R9 keep_en", keep_en, 1'b1);
        chk("R9 keep_lvl", keep_lvl, tdo);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic prev_tdi, prev_tms;
        repeat (3) @(posedge tckc);
        #1;
        chk("R1 tck", tap_tck, 1'b0);
        chk("R1 oe", tmsc_oe, 1'b0);
        chk("R1 tdi", tap_tdi, 1'b0);
        chk("R1 tms", tap_tms, 1'b0);
        chk("R1 keep_lvl", keep_lvl, 1'b0);
        chk("R1 keep_en", keep_en, 1'b0);
        rst_n = 1'b1;
        @(posedge tckc); #1;
        oscan_en = 1'b1;

        // Exhaustive sweep of packet contents
        for (int i = 0; i < 8; i++) begin
            send_pkt(i[0], i[1], i[2]);
        end
        for (int i = 7; i >= 0; i--) begin
            send_pkt(i[2], i[0], i[1]);
        end

        // R7: escape at the end of the nTDI slot
        prev_tdi = tap_tdi;
        prev_tms = tap_tms;
        @(negedge tckc); #1;
        probe  = prev_tdi;
        escape = 1'b1;
        @(posedge tckc); #1;
        escape = 1'b0;
        chk("R7 tdi kept", tap_tdi, prev_tdi);
        chk("R7 no tck", tap_tck, 1'b0);
        send_pkt(1'b1, 1'b1, 1'b0);

        // R7: escape at the end of the TMS slot
        send_pkt(1'b0, 1'b0, 1'b1);
        @(negedge tckc); #1;
        probe = 1'b0;
        @(posedge tckc); #1;
        chk("R7 tdi from slot 1", tap_tdi, 1'b1);
        @(negedge tckc); #1;
        probe   = 1'b1;
        tap_tdo = 1'b0;
        escape  = 1'b1;
        @(posedge tckc); #1;
        escape = 1'b0;
        chk("R7 tms kept", tap_tms, 1'b0);
        chk("R7 no tck at tms", tap_tck, 1'b0);
        send_pkt(1'b1, 1'b0, 1'b1);

        // R8: disabled, line toggles
        prev_tdi = tap_tdi;
        prev_tms = tap_tms;
        oscan_en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge tckc); #1;
            if (k > 0) chk("R9 keep_lvl line", keep_lvl, ~k[0]);
            chk("R8 keep_en off", keep_en, 1'b0);
            probe = k[0];
            @(posedge tckc); #1;
            chk("R8 no tck", tap_tck, 1'b0);
            chk("R8 no oe", tmsc_oe, 1'b0);
            chk("R8 tdi held", tap_tdi, prev_tdi);
            chk("R8 tms held", tap_tms, prev_tms);
        end
        oscan_en = 1'b1;
        send_pkt(1'b0, 1'b1, 1'b1);

        // R8: drop enable after one slot, then restart
        @(negedge tckc); #1;
        probe = 1'b0;
        @(posedge tckc); #1;
        oscan_en = 1'b0;
        @(negedge tckc); #1;
        probe = 1'b1;
        @(posedge tckc); #1;
        chk("R8 aborted no tck", tap_tck, 1'b0);
        oscan_en = 1'b1;
        send_pkt(1'b1, 1'b0, 1'b0);
        send_pkt(1'b0, 1'b1, 1'b1);

        summary();
        $finish;
    end

endmodule